// File: doc/BRIEF.md
# Indirect-Addressed Host Register Window

This block is the host-side register interface of a bus-protocol controller. The host sees only two byte locations. The address port takes a register number when written, and it returns the auxiliary status byte when read. The value port reads or writes whichever register the address port selected. Behind the window sits a bank of 26 byte registers. Registers 3 to 14 hold the command-descriptor bytes. Registers 18, 19 and 20 hold a 24-bit transfer counter. Register 23 holds the cause byte, register 24 the command and register 25 the data buffer.

Every value-port access steps the register pointer forward by one, so a multi-byte field can be streamed after one address write. The pointer does not step while it points at the data buffer, so repeated value accesses carry a stream of bytes through that one register. The command engine, the bus phases and the DMA sit outside this block. The engine supplies the busy, command-in-progress, parity and buffer-ready flags and loads the cause byte. The block returns a command strobe, the decoded command byte, a data-push strobe and the 24-bit count.

While the engine reports busy, the bank is fenced off from the host: only the command register, the data register and the status byte stay reachable. Command-in-progress also fences off the command register. A command written at the wrong time is dropped and the drop is flagged in the status byte.

Top module: `hostreg_window`

## Requirements
- R1: After synchronous reset, all 26 registers, the pointer, the interrupt-pending flag, the ignored-command flag and `host_rdata` are zero, and no strobe is high.
- R2: A write to the address port (`host_port`=0) loads the pointer from `host_wdata[4:0]`. A read of the address port returns the status byte {bit7 interrupt pending, bit6 last command ignored, bit5 `eng_busy`, bit4 `eng_cip`, bits3:2 zero, bit1 `eng_parity_err`, bit0 `eng_dbr`} and leaves the pointer unchanged.
- R3: Every value-port access (`host_port`=1) advances the pointer by one, except when the pointer is 25. `xfer_count` is {reg18, reg19, reg20}, so three writes after selecting 18 load it most-significant byte first.
- R4: A value-port read returns the selected register on `host_rdata` in the cycle after the access. `host_rdata` holds its value until the next read.
- R5: While `eng_busy` is high, a value-port write to registers 0 to 23 is dropped, and a read of them returns 0x00. The pointer still advances.
- R6: While `eng_cip` is high, a read of register 24 returns 0x00.
- R7: A write to register 24 while both `eng_busy` and `eng_cip` are low stores the byte. One cycle later `cmd_valid` pulses for one cycle, with `cmd_code` = bits 6:0 and `cmd_single` = bit 7.
- R8: A write to register 24 while `eng_busy` or `eng_cip` is high leaves register 24 unchanged, gives no strobe, and sets status bit 6. A status read clears bit 6 after returning it.
- R9: `eng_cause_we` loads register 23 and sets interrupt pending (`irq`, status bit 7). An unblocked host read of register 23 clears interrupt pending. An engine load wins over a clearing read, and over a host write to register 23, in the same cycle.
- R10: A write to register 25 pulses `data_push` one cycle later, with `data_byte` holding the byte. Register 25 is never fenced, and the pointer stays at 25.
- R11: Register numbers 26 to 31 are unmapped. Reads of them return 0x00, writes to them are dropped, and the pointer advances, wrapping from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host access strobe, one access per cycle |
| host_port | input | 1 | 0 = address/status port, 1 = value port |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read result, valid the cycle after a read |
| eng_busy | input | 1 | Engine busy flag |
| eng_cip | input | 1 | Engine command-in-progress flag |
| eng_parity_err | input | 1 | Parity error flag |
| eng_dbr | input | 1 | Data buffer ready flag |
| eng_cause_we | input | 1 | Engine loads the cause byte |
| eng_cause | input | 8 | Cause byte from the engine |
| irq | output | 1 | Interrupt pending |
| cmd_valid | output | 1 | One-cycle pulse when a command is accepted |
| cmd_code | output | 7 | Command code of register 24 |
| cmd_single | output | 1 | Single-byte qualifier of register 24 |
| data_push | output | 1 | One-cycle pulse after a data-buffer write |
| data_byte | output | 8 | Contents of register 25 |
| xfer_count | output | 24 | Transfer counter {reg18, reg19, reg20} |

## Verification
The assertions take for granted that the engine does not change its busy and command-in-progress flags in the cycle of a host access that they gate. They also assume that at most one host access arrives per clock. The stimulus changes the engine flags only between accesses, and it drives each access for exactly one cycle through a single task. The check that the transfer count stays put under a fenced write also assumes the engine is not loading the count. The engine has no path to the count, and the stimulus never drives it during those writes.

// File: rtl/hrw_pkg.sv
package hrw_pkg;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = 5;
    localparam int N_REGS   = 26;
    localparam int CNT_W    = 24;

    localparam logic [IDX_W-1:0] IDX_CNT_HI = 5'd18;
    localparam logic [IDX_W-1:0] IDX_CNT_MD = 5'd19;
    localparam logic [IDX_W-1:0] IDX_CNT_LO = 5'd20;
    localparam logic [IDX_W-1:0] IDX_CAUSE  = 5'd23;
    localparam logic [IDX_W-1:0] IDX_CMD    = 5'd24;
    localparam logic [IDX_W-1:0] IDX_DATA   = 5'd25;

    typedef struct packed {
        logic       int_pend;
        logic       cmd_lost;
        logic       busy;
        logic       cip;
        logic [1:0] zero;
        logic       parity;
        logic       dbr;
    } aux_status_t;

    typedef struct packed {
        logic       single;
        logic [6:0] code;
    } cmd_byte_t;

    typedef struct packed {
        logic ptr_wr;
        logic stat_rd;
        logic val_wr;
        logic val_rd;
    } host_op_t;

    function automatic logic idx_mapped(logic [IDX_W-1:0] idx);
        return idx <= IDX_DATA;
    endfunction

    function automatic logic idx_fenced(logic [IDX_W-1:0] idx, logic busy, logic cip);
        if (!idx_mapped(idx))  return 1'b1;
        if (idx == IDX_DATA)   return 1'b0;
        if (idx == IDX_CMD)    return cip;
        return busy;
    endfunction
endpackage

// File: rtl/hrw_ptr.sv
module hrw_ptr
    import hrw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (step && ptr != IDX_DATA)
            ptr <= ptr + 1'b1;
    end

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ptr != IDX_DATA) |=> ptr == $past(ptr) + 5'd1);

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ptr == IDX_DATA) |=> ptr == IDX_DATA);
endmodule

// File: rtl/hrw_status.sv
module hrw_status
    import hrw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        busy,
    input  logic        cip,
    input  logic        parity,
    input  logic        dbr,
    input  logic        cmd_ignored,
    input  logic        stat_rd,
    input  logic        cause_set,
    input  logic        cause_clr,
    output aux_status_t status,
    output logic        int_pend
);
    logic lost_q;
    logic int_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lost_q <= 1'b0;
            int_q  <= 1'b0;
        end else begin
            if (cmd_ignored)
                lost_q <= 1'b1;
            else if (stat_rd)
                lost_q <= 1'b0;

            if (cause_set)
                int_q <= 1'b1;
            else if (cause_clr)
                int_q <= 1'b0;
        end
    end

    always_comb begin
        status.int_pend = int_q;
        status.cmd_lost = lost_q;
        status.busy     = busy;
        status.cip      = cip;
        status.zero     = 2'b00;
        status.parity   = parity;
        status.dbr      = dbr;
    end

    assign int_pend = int_q;

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(int_q) |-> $past(cause_clr));

    // R8
    lost_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_q) |-> $past(cmd_ignored));

    // R8
    lost_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lost_q) |-> $past(stat_rd));
endmodule

// File: rtl/hrw_bank.sv
module hrw_bank
    import hrw_pkg::*;
#(
    parameter int NREG = N_REGS,
    parameter int DW   = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             eng_we,
    input  logic [DW-1:0]    eng_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic [3*DW-1:0]  count,
    output logic [DW-1:0]    cmd_reg,
    output logic [DW-1:0]    data_reg
);
    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] nxt  [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == int'(IDX_CAUSE)) begin : g_cause
            assign nxt[g] = eng_we ? eng_data :
                            (wr_en && wr_idx == IDX_W'(g)) ? wr_data : regs[g];
        end else begin : g_plain
            assign nxt[g] = (wr_en && wr_idx == IDX_W'(g)) ? wr_data : regs[g];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++)
            regs[i] <= rst ? '0 : nxt[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IDX_W'(i))
                rd_data = regs[i];
    end

    assign count    = {regs[IDX_CNT_HI], regs[IDX_CNT_MD], regs[IDX_CNT_LO]};
    assign cmd_reg  = regs[IDX_CMD];
    assign data_reg = regs[IDX_DATA];
endmodule

// File: rtl/hostreg_window.sv
module hostreg_window
    import hrw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic              host_port,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              eng_busy,
    input  logic              eng_cip,
    input  logic              eng_parity_err,
    input  logic              eng_dbr,
    input  logic              eng_cause_we,
    input  logic [DATA_W-1:0] eng_cause,
    output logic              irq,
    output logic              cmd_valid,
    output logic [6:0]        cmd_code,
    output logic              cmd_single,
    output logic              data_push,
    output logic [DATA_W-1:0] data_byte,
    output logic [CNT_W-1:0]  xfer_count
);
    host_op_t          op;
    logic [IDX_W-1:0]  ptr;
    logic              fenced;
    logic              is_cmd;
    logic              cmd_ok;
    logic              bank_we;
    logic              cmd_ignored;
    logic              cause_clr;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] cmd_raw;
    aux_status_t       status;
    cmd_byte_t         cmd_dec;
    logic [DATA_W-1:0] rdata_q;
    logic              cmd_valid_q;
    logic              push_q;

    always_comb begin
        op.ptr_wr  = host_cs && !host_port &&  host_we;
        op.stat_rd = host_cs && !host_port && !host_we;
        op.val_wr  = host_cs &&  host_port &&  host_we;
        op.val_rd  = host_cs &&  host_port && !host_we;
    end

    assign fenced      = idx_fenced(ptr, eng_busy, eng_cip);
    assign is_cmd      = (ptr == IDX_CMD);
    assign cmd_ok      = !eng_busy && !eng_cip;
    assign bank_we     = op.val_wr && (is_cmd ? cmd_ok : !fenced);
    assign cmd_ignored = op.val_wr && is_cmd && !cmd_ok;
    assign cause_clr   = op.val_rd && (ptr == IDX_CAUSE) && !fenced;

    hrw_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (op.ptr_wr),
        .load_val (host_wdata[IDX_W-1:0]),
        .step     (op.val_wr || op.val_rd),
        .ptr      (ptr)
    );

    hrw_status u_status (
        .clk         (clk),
        .rst         (rst),
        .busy        (eng_busy),
        .cip         (eng_cip),
        .parity      (eng_parity_err),
        .dbr         (eng_dbr),
        .cmd_ignored (cmd_ignored),
        .stat_rd     (op.stat_rd),
        .cause_set   (eng_cause_we),
        .cause_clr   (cause_clr),
        .status      (status),
        .int_pend    (irq)
    );

    hrw_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bank_we),
        .wr_idx   (ptr),
        .wr_data  (host_wdata),
        .eng_we   (eng_cause_we),
        .eng_data (eng_cause),
        .rd_idx   (ptr),
        .rd_data  (bank_rd),
        .count    (xfer_count),
        .cmd_reg  (cmd_raw),
        .data_reg (data_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q     <= '0;
            cmd_valid_q <= 1'b0;
            push_q      <= 1'b0;
        end else begin
            if (op.stat_rd)
                rdata_q <= status;
            else if (op.val_rd)
                rdata_q <= fenced ? '0 : bank_rd;
            cmd_valid_q <= bank_we && is_cmd;
            push_q      <= bank_we && (ptr == IDX_DATA);
        end
    end

    assign cmd_dec    = cmd_byte_t'(cmd_raw);
    assign cmd_code   = cmd_dec.code;
    assign cmd_single = cmd_dec.single;
    assign cmd_valid  = cmd_valid_q;
    assign data_push  = push_q;
    assign host_rdata = rdata_q;

    // R7
    cmd_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(!eng_busy && !eng_cip));

    // R5
    fenced_count_chk: assert property (@(posedge clk) disable iff (rst)
        (op.val_wr && eng_busy && ptr >= IDX_CNT_HI && ptr <= IDX_CNT_LO)
        |=> $stable(xfer_count));

    // R6
    cip_read_chk: assert property (@(posedge clk) disable iff (rst)
        (op.val_rd && eng_cip && is_cmd) |=> host_rdata == 8'h00);

    // R2
    status_rd_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        op.stat_rd |=> $stable(ptr));

    // R10
    push_data_chk: assert property (@(posedge clk) disable iff (rst)
        (op.val_wr && ptr == IDX_DATA) |=> (data_push && data_byte == $past(host_wdata)));
endmodule

// File: tb/test_hostreg_window.sv
`timescale 1ns/1ps
module test_hostreg_window;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 0, port = 0, we = 0;
    logic [7:0] wd = 0;
    logic busy = 0, cip = 0, par = 0, dbr = 0, cwe = 0;
    logic [7:0] cause = 0;
    logic [7:0] rdata;
    logic irq, cmd_valid, cmd_single, data_push;
    logic [6:0] cmd_code;
    logic [7:0] data_byte;
    logic [23:0] xfer_count;

    always #2.5 clk = ~clk;

    hostreg_window i_hostreg_window (
        .clk(clk), .rst(rst), .host_cs(cs), .host_port(port), .host_we(we),
        .host_wdata(wd), .host_rdata(rdata), .eng_busy(busy), .eng_cip(cip),
        .eng_parity_err(par), .eng_dbr(dbr), .eng_cause_we(cwe), .eng_cause(cause),
        .irq(irq), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_single(cmd_single),
        .data_push(data_push), .data_byte(data_byte), .xfer_count(xfer_count));

    int n_chk = 0, n_bad = 0;
    string tag = "R1";

    // reference model
    int m_reg [26];
    int m_ptr = 0;
    bit m_int = 0, m_lost = 0;
    int e_rd = 0;
    bit e_cv = 0, e_push = 0;

    task automatic chk(string t, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    function automatic bit m_fenced(int idx);
        if (idx > 25) return 1;
        if (idx == 25) return 0;
        if (idx == 24) return cip;
        return busy;
    endfunction

    task automatic model_update();
        int idx;
        bit fen, clr;
        clr = 0;
        e_cv = 0;
        e_push = 0;
        idx = m_ptr;
        fen = m_fenced(idx);
        if (cs && !port && !we) begin
            e_rd = {m_int, m_lost, busy, cip, 2'b00, par, dbr};
            m_lost = 0;
        end else if (cs && port && !we) begin
            e_rd = fen ? 0 : m_reg[idx];
            if (idx == 23 && !fen) clr = 1;
        end
        if (cs && port && we) begin
            if (idx == 24) begin
                if (!busy && !cip) begin m_reg[24] = wd; e_cv = 1; end
                else m_lost = 1;
            end else if (!fen) begin
                if (!(idx == 23 && cwe)) m_reg[idx] = wd;
                if (idx == 25) e_push = 1;
            end
        end
        if (cwe) m_reg[23] = cause;
        if (cwe) m_int = 1;
        else if (clr) m_int = 0;
        if (cs && !port && we) m_ptr = wd[4:0];
        else if (cs && port && idx != 25) m_ptr = (m_ptr + 1) % 32;
    endtask

    task automatic compare_all();
        chk(tag, "rdata", rdata, e_rd);
        chk(tag, "irq", irq, m_int);
        chk(tag, "cmd_valid", cmd_valid, e_cv);
        chk(tag, "cmd_code", cmd_code, m_reg[24] & 8'h7f);
        chk(tag, "cmd_single", cmd_single, (m_reg[24] >> 7) & 1);
        chk(tag, "data_push", data_push, e_push);
        chk(tag, "data_byte", data_byte, m_reg[25]);
        chk(tag, "xfer_count", xfer_count, (m_reg[18] << 16) | (m_reg[19] << 8) | m_reg[20]);
    endtask

    // one clock: drive at negedge, model after posedge, compare at next negedge
    task automatic step(bit c, bit p, bit w, logic [7:0] d);
        cs = c; port = p; we = w; wd = d;
        @(posedge clk);
        #0.5;
        model_update();
        @(negedge clk);
        cs = 0; cwe = 0;
        compare_all();
    endtask

    task automatic set_ptr(int n);   step(1, 0, 1, 8'(n)); endtask
    task automatic wr(logic [7:0] d); step(1, 1, 1, d); endtask
    task automatic rd();              step(1, 1, 0, 8'h00); endtask
    task automatic srd();             step(1, 0, 0, 8'h00); endtask
    task automatic idle();            step(0, 0, 0, 8'h00); endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        foreach (m_reg[i]) m_reg[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        tag = "R1";
        compare_all();
        srd();
        chk("R1", "status after reset", rdata, 8'h00);

        // R2: status byte bits and pointer untouched by status read
        tag = "R2";
        par = 1; dbr = 1;
        srd();
        chk("R2", "status parity/dbr", rdata, 8'h03);
        par = 0; dbr = 0;
        set_ptr(5); wr(8'h5A);
        set_ptr(5); srd(); rd();
        chk("R2", "reg5 after status read", rdata, 8'h5A);

        // R3/R4: stream descriptor bytes 3..14, read back
        tag = "R3";
        set_ptr(3);
        for (int i = 0; i < 12; i++) wr(8'(8'h10 + i * 7));
        tag = "R4";
        set_ptr(3);
        for (int i = 0; i < 12; i++) begin
            rd();
            chk("R4", "descriptor readback", rdata, 8'(8'h10 + i * 7));
        end
        idle();
        chk("R4", "rdata held", rdata, 8'(8'h10 + 11 * 7));

        // R3: 24-bit counter, most-significant first
        tag = "R3";
        set_ptr(18); wr(8'hAB); wr(8'hCD); wr(8'hEF);
        chk("R3", "xfer_count", xfer_count, 24'hABCDEF);
        set_ptr(18); rd(); rd(); rd();
        chk("R3", "count low byte via stream", rdata, 8'hEF);

        // R5: busy fences 0..23, pointer still advances
        tag = "R5";
        busy = 1;
        set_ptr(18); wr(8'h11); wr(8'h22); wr(8'h33);
        chk("R5", "count unchanged", xfer_count, 24'hABCDEF);
        set_ptr(19); rd();
        chk("R5", "fenced read zero", rdata, 8'h00);
        set_ptr(23); rd(); rd();
        chk("R5", "cmd readable while busy", rdata, 8'h00);
        busy = 0;
        set_ptr(19); rd();
        chk("R5", "reg19 kept", rdata, 8'hCD);

        // R7: accepted command
        tag = "R7";
        set_ptr(24); wr(8'h85);
        chk("R7", "cmd_valid", cmd_valid, 1);
        chk("R7", "cmd_code", cmd_code, 7'h05);
        chk("R7", "cmd_single", cmd_single, 1);
        idle();
        chk("R7", "cmd_valid one cycle", cmd_valid, 0);

        // R8: ignored command under busy and under cip
        tag = "R8";
        busy = 1;
        set_ptr(24); wr(8'h07);
        chk("R8", "no strobe", cmd_valid, 0);
        busy = 0;
        srd();
        chk("R8", "lost bit set", rdata, 8'h40);
        srd();
        chk("R8", "lost bit cleared", rdata, 8'h00);
        cip = 1;
        set_ptr(24); wr(8'h09);
        chk("R8", "cmd code kept", cmd_code, 7'h05);
        // R6: cip fences command read
        tag = "R6";
        set_ptr(24); rd();
        chk("R6", "cmd read under cip", rdata, 8'h00);
        srd();
        chk("R6", "status cip+lost", rdata, 8'h50);
        cip = 0;

        // R9: cause load, clear by read, set wins
        tag = "R9";
        cwe = 1; cause = 8'h42; idle();
        chk("R9", "irq set", irq, 1);
        set_ptr(23); rd();
        chk("R9", "cause read", rdata, 8'h42);
        chk("R9", "irq cleared", irq, 0);
        set_ptr(23);
        cwe = 1; cause = 8'h81; rd();
        chk("R9", "set wins over clear", irq, 1);
        set_ptr(23); cwe = 1; cause = 8'h16; wr(8'hEE);
        set_ptr(23); rd();
        chk("R9", "engine wins over host write", rdata, 8'h16);

        // R10: data stream through register 25
        tag = "R10";
        busy = 1;
        set_ptr(25);
        for (int i = 0; i < 5; i++) begin
            wr(8'(8'hC0 + i));
            chk("R10", "push", data_push, 1);
            chk("R10", "data_byte", data_byte, 8'(8'hC0 + i));
        end
        rd(); rd();
        chk("R10", "pointer held at 25", rdata, 8'hC4);
        busy = 0;

        // R11: unmapped numbers and wrap
        tag = "R11";
        set_ptr(0); wr(8'h3C);
        set_ptr(30); wr(8'h99); rd();
        chk("R11", "unmapped read", rdata, 8'h00);
        rd();
        chk("R11", "reg0 after wrap", rdata, 8'h3C);

        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule